// File: doc/BRIEF.md
# Receive Interrupt Pending and Service Controller

This block sits beside the receive FIFO of one frame-based synchronous serial channel and decides when that channel asks for service. It holds the received characters together with an end-of-frame marker. It keeps an occupancy count of the complete frames queued in the FIFO. It also holds two interrupt sources, a special condition (end of frame or overrun) and receive character available, each with a pending bit and an in-service bit.

Software or a DMA engine drains the FIFO through a read strobe. It acknowledges interrupts and ends their service with a reset-highest-in-service command. An error-reset command clears error state.

Two receive interrupt modes are selected by `mode_i`, which is changed only while the block is held in reset. In special-condition-only mode the FIFO never locks. A reset-highest-in-service command also clears pending requests, including ones that were never acknowledged. In first-character mode the FIFO locks once the end-of-frame character has been read out. That condition then stays pending until an error reset is issued. In both modes `frame_avail_o` tells software whether a complete frame is still queued, even after a pending request has been lost.

Top module: `rxi_ctrl`

## Requirements
- R1: After reset `irq_o`, `ip_o`, `ius_o`, `frame_avail_o`, `locked_o` and `overrun_o` are 0 and `rx_empty_o` is 1.
- R2: Accepted characters leave the FIFO in arrival order. `rd_data_o` and `rd_eof_o` show the oldest entry, and a read strobe while `rx_empty_o` is 1 changes nothing.
- R3: `frame_avail_o` is 1 while at least one end-of-frame character is stored. At most 10 frames are counted, and an end-of-frame character arriving while 10 are stored is dropped and sets `overrun_o`.
- R4: With `mode_i`=0, reading an end-of-frame character out sets both `ip_o[1]` (special condition) and `ip_o[0]` (character available), and `locked_o` stays 0.
- R5: With `mode_i`=0, `rst_ius_i` clears every pending bit whether or not it was acknowledged, unless a new event sets it in the same cycle.
- R6: With `mode_i`=1, the first character accepted after reset or after an end-of-frame character sets `ip_o[0]`. An accepted read clears it, and a set in the same cycle wins.
- R7: With `mode_i`=1, reading an end-of-frame character out sets `ip_o[1]` and `locked_o`. While locked, received characters are dropped and set `overrun_o`, and reads still work.
- R8: With `mode_i`=1, `rst_ius_i` never clears a pending bit. `err_rst_i` clears `locked_o`, `overrun_o` and `ip_o[1]` in one cycle.
- R9: Source 1 outranks source 0. `irq_o` is 1 exactly when a pending source ranks above every in-service source.
- R10: `ack_i` with `irq_o`=1 sets the in-service bit of the highest qualifying pending source, and is otherwise ignored. `rst_ius_i` clears only the highest set in-service bit and takes precedence over a simultaneous `ack_i`.
- R11: A character that arrives while the FIFO is full is dropped, sets `overrun_o` and sets `ip_o[1]`, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 special condition only, 1 first character plus special condition |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | DW | Received character |
| rx_eof_i | input | 1 | Character ends a frame |
| rd_i | input | 1 | Read strobe from host or DMA |
| ack_i | input | 1 | Interrupt acknowledge |
| rst_ius_i | input | 1 | Reset highest in-service command |
| err_rst_i | input | 1 | Error reset command |
| rd_data_o | output | DW | Oldest stored character |
| rd_eof_o | output | 1 | Oldest stored character ends a frame |
| rx_empty_o | output | 1 | FIFO holds no character |
| irq_o | output | 1 | Interrupt request |
| ip_o | output | 2 | Pending bits, [1] special condition, [0] character available |
| ius_o | output | 2 | In-service bits, same order |
| frame_avail_o | output | 1 | At least one complete frame queued |
| locked_o | output | 1 | FIFO locked after end of frame |
| overrun_o | output | 1 | A character was dropped |

## Verification
The hardest state to reach is a nested one: the character-available source is already in service when a special condition becomes pending on top of it, followed by two successive in-service resets that must leave the locked condition pending. The stimulus reaches it in first-character mode. It acknowledges the first-character request and then drains the frame, so that the end-of-frame read raises the higher source while the lower one is still in service. The lost-request behaviour of the other mode is reached by reading an end-of-frame character and issuing the in-service reset with no acknowledge in between.

// File: rtl/rxi_pkg.sv
package rxi_pkg;
  localparam int unsigned NSRC     = 2;
  localparam int unsigned SRC_RCA  = 0;
  localparam int unsigned SRC_SPEC = 1;

  typedef enum logic {
    MODE_SPEC_ONLY  = 1'b0,
    MODE_FIRST_CHAR = 1'b1
  } rx_mode_e;
endpackage

// File: rtl/rxi_rx_fifo.sv
module rxi_rx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_eof_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_eof_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW:0]   mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wp_q] <= {wr_eof_i, wr_data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (rd_i) rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({wr_i, rd_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_data_o = mem_q[rp_q][DW-1:0];
  assign rd_eof_o  = mem_q[rp_q][DW] & ~empty_o;
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign empty_o   = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_i |-> cnt_q < CW'(DEPTH)); // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) rd_i |-> cnt_q != '0); // R2
endmodule

// File: rtl/rxi_frame_cnt.sv
module rxi_frame_cnt #(
  parameter int unsigned DEPTH = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic full_o,
  output logic avail_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      case ({inc_i, dec_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign avail_o = (cnt_q != '0);

  AST_FRAME_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) dec_i |-> cnt_q != '0); // R3
  AST_FRAME_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni) inc_i |-> cnt_q < CW'(DEPTH)); // R3
endmodule

// File: rtl/rxi_prio.sv
module rxi_prio #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] ip_i,
  input  logic            ack_i,
  input  logic            rst_ius_i,
  output logic [NSRC-1:0] ius_o,
  output logic            irq_o
);
  logic [NSRC-1:0] ius_q, open_m, cand, grant, top_ius;

  // a source qualifies only if no in-service bit at or above its rank
  always_comb begin
    logic blocked, found, hit;
    blocked = 1'b0;
    found   = 1'b0;
    hit     = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      blocked   = blocked | ius_q[i];
      open_m[i] = ~blocked;
    end
    cand = ip_i & open_m;
    for (int i = NSRC - 1; i >= 0; i--) begin
      grant[i]   = cand[i] & ~found;
      found      = found | cand[i];
      top_ius[i] = ius_q[i] & ~hit;
      hit        = hit | ius_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ius_q <= '0;
    else if (rst_ius_i) ius_q <= ius_q & ~top_ius;
    else if (ack_i)     ius_q <= ius_q | grant;
  end

  assign ius_o = ius_q;
  assign irq_o = |cand;

  AST_ACK_ADDS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !rst_ius_i && irq_o |=> $countones(ius_q) == $past($countones(ius_q)) + 1); // R10
  AST_RST_DROPS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ius_i && (ius_q != '0) |=> $countones(ius_q) + 1 == $past($countones(ius_q))); // R10
  AST_ACK_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !irq_o && !rst_ius_i |=> $stable(ius_q)); // R10
endmodule

// File: rtl/rxi_ctrl.sv
module rxi_ctrl
  import rxi_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned RX_DEPTH    = 16,
  parameter int unsigned FRAME_DEPTH = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_i,
  input  logic            rx_valid_i,
  input  logic [DW-1:0]   rx_data_i,
  input  logic            rx_eof_i,
  input  logic            rd_i,
  input  logic            ack_i,
  input  logic            rst_ius_i,
  input  logic            err_rst_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            rd_eof_o,
  output logic            rx_empty_o,
  output logic            irq_o,
  output logic [NSRC-1:0] ip_o,
  output logic [NSRC-1:0] ius_o,
  output logic            frame_avail_o,
  output logic            locked_o,
  output logic            overrun_o
);
  rx_mode_e mode;
  logic fifo_full, fifo_empty, head_eof, frame_full;
  logic wr_ok, drop, rd_ok, eof_rd;
  logic locked_q, overrun_q, frame_start_q;
  logic [NSRC-1:0] ip_q, ip_set, ip_clr;

  assign mode = rx_mode_e'(mode_i);

  assign wr_ok  = rx_valid_i & ~fifo_full & ~locked_q & ~(rx_eof_i & frame_full);
  assign drop   = rx_valid_i & ~wr_ok;
  assign rd_ok  = rd_i & ~fifo_empty;
  assign eof_rd = rd_ok & head_eof;

  rxi_rx_fifo #(.DW(DW), .DEPTH(RX_DEPTH)) i_rx_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_ok),
    .wr_data_i (rx_data_i),
    .wr_eof_i  (rx_eof_i),
    .rd_i      (rd_ok),
    .rd_data_o (rd_data_o),
    .rd_eof_o  (head_eof),
    .full_o    (fifo_full),
    .empty_o   (fifo_empty)
  );

  rxi_frame_cnt #(.DEPTH(FRAME_DEPTH)) i_frame_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (wr_ok & rx_eof_i),
    .dec_i   (eof_rd),
    .full_o  (frame_full),
    .avail_o (frame_avail_o)
  );

  // special condition: end of frame read out or a dropped character
  always_comb begin
    ip_set = '0;
    ip_clr = '0;
    ip_set[SRC_SPEC] = eof_rd | drop;
    ip_clr[SRC_SPEC] = err_rst_i | ((mode == MODE_SPEC_ONLY) & rst_ius_i);
    if (mode == MODE_FIRST_CHAR) begin
      ip_set[SRC_RCA] = wr_ok & frame_start_q;
      ip_clr[SRC_RCA] = rd_ok;
    end else begin
      ip_set[SRC_RCA] = eof_rd;
      ip_clr[SRC_RCA] = rst_ius_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_q          <= '0;
      locked_q      <= 1'b0;
      overrun_q     <= 1'b0;
      frame_start_q <= 1'b1;
    end else begin
      ip_q <= ip_set | (ip_q & ~ip_clr);
      if (err_rst_i)                                locked_q <= 1'b0;
      else if (eof_rd && mode == MODE_FIRST_CHAR)   locked_q <= 1'b1;
      if (err_rst_i)  overrun_q <= 1'b0;
      else if (drop)  overrun_q <= 1'b1;
      if (wr_ok) frame_start_q <= rx_eof_i;
    end
  end

  rxi_prio #(.NSRC(NSRC)) i_prio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ip_i      (ip_q),
    .ack_i     (ack_i),
    .rst_ius_i (rst_ius_i),
    .ius_o     (ius_o),
    .irq_o     (irq_o)
  );

  assign ip_o       = ip_q;
  assign rd_eof_o   = head_eof;
  assign rx_empty_o = fifo_empty;
  assign locked_o   = locked_q;
  assign overrun_o  = overrun_q;

  AST_LOCK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q && rx_valid_i && !err_rst_i |=> overrun_o); // R7
  AST_MODE1_SPEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i && !err_rst_i && ip_q[SRC_SPEC] |=> ip_o[SRC_SPEC]); // R8
  AST_MODE0_NO_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i && !locked_q |=> !locked_o); // R4
  AST_MODE0_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i && rst_ius_i && !rd_i && !rx_valid_i |=> ip_o == '0); // R5
  AST_IRQ_NEEDS_IP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ip_q != '0); // R9
endmodule

// File: tb/test_rxi_ctrl.sv
module test_rxi_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_eof_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       rst_ius_i = 1'b0;
  logic       err_rst_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       rd_eof_o, rx_empty_o, irq_o, frame_avail_o, locked_o, overrun_o;
  logic [1:0] ip_o, ius_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [8:0] exp_q[$];

  always #2 clk_i = ~clk_i;

  rxi_ctrl i_rxi_ctrl (
    .clk_i, .rst_ni, .mode_i, .rx_valid_i, .rx_data_i, .rx_eof_i, .rd_i,
    .ack_i, .rst_ius_i, .err_rst_i, .rd_data_o, .rd_eof_o, .rx_empty_o,
    .irq_o, .ip_o, .ius_o, .frame_avail_o, .locked_o, .overrun_o
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compares the FIFO head with the scoreboard on every real read (R2)
  always @(negedge clk_i) begin
    if (rst_ni && rd_i && !rx_empty_o) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected read: actual %0h expected none", {rd_eof_o, rd_data_o});
      end else begin
        if ({rd_eof_o, rd_data_o} !== exp_q[0]) begin
          n_fail++;
          $display("FAIL R2 read order: actual %0h expected %0h", {rd_eof_o, rd_data_o}, exp_q[0]);
        end
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic cyc();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset(logic m);
    rst_ni = 1'b0;
    mode_i = m;
    exp_q.delete();
    repeat (2) cyc();
    rst_ni = 1'b1;
    cyc();
  endtask

  // driver: predicts acceptance and queues the expected entry
  task automatic put(logic [7:0] d, logic eof, logic accept);
    rx_valid_i = 1'b1;
    rx_data_i  = d;
    rx_eof_i   = eof;
    if (accept) exp_q.push_back({eof, d});
    cyc();
    rx_valid_i = 1'b0;
    rx_eof_i   = 1'b0;
  endtask

  task automatic get();
    rd_i = 1'b1;
    cyc();
    rd_i = 1'b0;
  endtask

  task automatic ack();
    ack_i = 1'b1;
    cyc();
    ack_i = 1'b0;
  endtask

  task automatic rius();
    rst_ius_i = 1'b1;
    cyc();
    rst_ius_i = 1'b0;
  endtask

  task automatic erst();
    err_rst_i = 1'b1;
    cyc();
    err_rst_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(1'b0);
    chk("R1", "irq", irq_o, 0);
    chk("R1", "ip", ip_o, 0);
    chk("R1", "ius", ius_o, 0);
    chk("R1", "frame_avail", frame_avail_o, 0);
    chk("R1", "locked", locked_o, 0);
    chk("R1", "overrun", overrun_o, 0);
    chk("R1", "empty", rx_empty_o, 1);

    // special-condition-only mode
    put(8'h11, 1'b0, 1'b1);
    put(8'h22, 1'b1, 1'b1);
    chk("R3", "avail after eof write", frame_avail_o, 1);
    chk("R4", "no ip on plain write", ip_o, 0);
    get();
    chk("R4", "no ip on plain read", ip_o, 0);
    get();
    chk("R4", "ip after eof read", ip_o, 2'b11);
    chk("R4", "no lock in mode 0", locked_o, 0);
    chk("R3", "avail after last frame read", frame_avail_o, 0);
    chk("R9", "irq pending", irq_o, 1);
    ack();
    chk("R10", "ack grants special", ius_o, 2'b10);
    chk("R9", "irq masked by ius", irq_o, 0);
    ack();
    chk("R10", "ack without irq ignored", ius_o, 2'b10);
    rius();
    chk("R5", "rst ius clears ius", ius_o, 0);
    chk("R5", "rst ius clears unacked ip", ip_o, 0);
    put(8'h33, 1'b1, 1'b1);
    get();
    chk("R4", "ip after second eof", ip_o, 2'b11);
    rius();
    chk("R5", "request lost without ack", ip_o, 0);
    chk("R5", "irq gone", irq_o, 0);

    // R11 full FIFO overrun
    for (int i = 0; i < 16; i++) put(8'(8'h80 + i), 1'b0, 1'b1);
    chk("R11", "no overrun yet", overrun_o, 0);
    put(8'hEE, 1'b0, 1'b0);
    chk("R11", "overrun on full", overrun_o, 1);
    chk("R11", "special ip on overrun", ip_o, 2'b10);
    for (int i = 0; i < 16; i++) get();
    chk("R2", "empty after drain", rx_empty_o, 1);
    get();
    chk("R2", "read on empty keeps empty", rx_empty_o, 1);
    chk("R2", "read on empty keeps ip", ip_o, 2'b10);
    erst();
    chk("R11", "overrun cleared", overrun_o, 0);
    chk("R11", "special ip cleared", ip_o, 0);

    // R3 frame count limit
    for (int i = 0; i < 10; i++) put(8'(8'h40 + i), 1'b1, 1'b1);
    chk("R3", "ten frames accepted", overrun_o, 0);
    put(8'h4F, 1'b1, 1'b0);
    chk("R3", "eleventh frame dropped", overrun_o, 1);
    erst();
    for (int i = 0; i < 9; i++) get();
    chk("R3", "one frame left", frame_avail_o, 1);
    get();
    chk("R3", "no frame left", frame_avail_o, 0);
    chk("R2", "fifo empty", rx_empty_o, 1);

    // first-character mode
    do_reset(1'b1);
    put(8'h41, 1'b0, 1'b1);
    chk("R6", "first char sets rca", ip_o, 2'b01);
    chk("R9", "irq for rca", irq_o, 1);
    put(8'h42, 1'b0, 1'b1);
    ack();
    chk("R10", "ack grants rca", ius_o, 2'b01);
    chk("R9", "irq masked", irq_o, 0);
    put(8'h43, 1'b1, 1'b1);
    chk("R6", "no rca mid frame", ip_o, 2'b01);
    get();
    chk("R6", "read clears rca", ip_o, 2'b00);
    get();
    get();
    chk("R7", "eof read sets special", ip_o, 2'b10);
    chk("R7", "locked", locked_o, 1);
    chk("R9", "nested irq above rca", irq_o, 1);
    ack();
    chk("R10", "nested ack", ius_o, 2'b11);
    rius();
    chk("R10", "rst ius clears top only", ius_o, 2'b01);
    chk("R8", "ip kept after rst ius", ip_o, 2'b10);
    rius();
    chk("R10", "second rst ius", ius_o, 2'b00);
    chk("R8", "ip still kept", ip_o, 2'b10);
    chk("R9", "irq again", irq_o, 1);
    put(8'h50, 1'b0, 1'b0);
    chk("R7", "dropped while locked", overrun_o, 1);
    chk("R7", "nothing stored", rx_empty_o, 1);
    rst_ius_i = 1'b1;
    ack_i = 1'b1;
    cyc();
    rst_ius_i = 1'b0;
    ack_i = 1'b0;
    chk("R10", "ack ignored with rst ius", ius_o, 2'b00);
    erst();
    chk("R8", "err rst unlocks", locked_o, 0);
    chk("R8", "err rst clears overrun", overrun_o, 0);
    chk("R8", "err rst clears special", ip_o, 2'b00);
    put(8'h51, 1'b0, 1'b1);
    chk("R6", "first char of next frame", ip_o, 2'b01);
    get();
    chk("R2", "drained", rx_empty_o, 1);
    repeat (2) cyc();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule